// File: doc/BRIEF.md
# Throttled Miss Request Queue

This block holds outstanding requests that one cache level sends to the next. Each cycle it can take in one demand request and one prefetch request. Both kinds go into one shared first-in first-out store. When the two arrive in the same cycle, the demand is written into the earlier slot. Otherwise the two kinds get no relative priority. Every request names a whole cache block, so the low offset bits of the incoming virtual address are cleared before the request is stored. The address is not translated.

Requests leave through a valid/ready port that carries the block address and a type bit. A programmable pacing setting spaces out the departures. After each departure a countdown is loaded with the setting minus one, and the next head entry may leave only once that countdown has reached zero. A setting of 0 or 1 lets an entry leave on every cycle. The block reports its occupancy and a full flag. The full flag, and a nearly full store, withdraw the accept-ready signals.

Top module: `miss_req_queue`

## Requirements
- R1: Accepted requests of both kinds leave in the order they were accepted. A request is accepted when its valid and ready are both high at a clock edge. A departure is a clock edge with `out_valid` and `out_ready` both high.
- R2: When a demand and a prefetch are both accepted at the same edge, the demand leaves before that prefetch.
- R3: `out_addr` equals the accepted address with its low `BLK_OFF_W` bits forced to 0. All upper bits are unchanged.
- R4: `out_is_pf` is 1 for an entry that came in on the prefetch port and 0 for one that came in on the demand port.
- R5: With `gap_cfg` = N ≥ 2, successive departures are at least N cycles apart. While the queue stays non-empty and `out_ready` stays high, the spacing is exactly N.
- R6: With `gap_cfg` = 0 or 1, a non-empty queue with `out_ready` high gives a departure on every cycle.
- R7: `full` is 1 exactly when `occupancy` equals DEPTH (default 16). While `full` is 1, `dmd_ready` and `pf_ready` are 0.
- R8: When exactly one slot is free and both valids are high, `dmd_ready` is 1 and `pf_ready` is 0. Only the demand is stored.
- R9: After reset, `occupancy` is 0, `full` is 0 and `out_valid` is 0. The pacing countdown is cleared, so a request accepted after reset is offered on `out_valid` in the very next cycle, whatever `gap_cfg` is.
- R10: While `out_valid` is 1 and `out_ready` is 0, `out_valid` stays 1 and `out_addr` and `out_is_pf` hold their values.
- R11: `occupancy` follows the number of accepted requests minus the number of departures, and is updated one cycle after the edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously |
| dmd_valid | input | 1 | A demand request is presented |
| dmd_addr | input | ADDR_W | Virtual address of the demand request |
| dmd_ready | output | 1 | The demand request can be taken |
| pf_valid | input | 1 | A prefetch request is presented |
| pf_addr | input | ADDR_W | Virtual address of the prefetch request |
| pf_ready | output | 1 | The prefetch request can be taken |
| gap_cfg | input | GAP_W | Minimum number of cycles between departures (0 and 1 mean every cycle) |
| out_valid | output | 1 | The head entry is offered to the next level |
| out_ready | input | 1 | The next level takes the head entry |
| out_addr | output | ADDR_W | Block-aligned address of the head entry |
| out_is_pf | output | 1 | The head entry is a prefetch (1) or a demand (0) |
| occupancy | output | CNT_W | Number of stored entries |
| full | output | 1 | All DEPTH slots are occupied |

## Verification
A corrupted read or write pointer shows up at the next departure: an entry comes out in the wrong order, twice, or with an address that was never sent, and the scoreboard flags it on that same cycle. A countdown that is off by one, or that is not cleared, shows up between two back-to-back departures as a change in spacing, or after reset as a late first offer. A bad occupancy count shows up within one cycle in `occupancy`, `full` or the ready outputs, and it also leaves entries missing or extra when the queue is drained.

// File: rtl/mrq_pkg.sv
package mrq_pkg;

  // Origin of a stored entry; the encoding is what appears on out_is_pf.
  typedef enum logic {
    REQ_DEMAND   = 1'b0,
    REQ_PREFETCH = 1'b1
  } req_kind_e;

  // Clear the block offset bits of an address.
  function automatic logic [63:0] block_align(input logic [63:0] addr, input int unsigned off_w);
    logic [63:0] mask;
    mask = (off_w == 0) ? '1 : ~((64'd1 << off_w) - 64'd1);
    return addr & mask;
  endfunction

endpackage

// File: rtl/mrq_admit.sv
module mrq_admit #(
  parameter int unsigned DEPTH = 16,
  parameter int unsigned CNT_W = $clog2(DEPTH + 1)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             dmd_valid,
  input  logic             pf_valid,
  input  logic [CNT_W-1:0] count,
  output logic             dmd_ready,
  output logic             pf_ready,
  output logic             take_dmd,
  output logic             take_pf,
  output logic             full
);

  logic [CNT_W-1:0] free_slots;
  logic             room_one;
  logic             room_two;

  always_comb begin
    free_slots = CNT_W'(DEPTH) - count;
    room_one   = (free_slots != '0);
    room_two   = (free_slots >= CNT_W'(2));
    full       = (count == CNT_W'(DEPTH));
    // The demand claims the first free slot; the prefetch needs a second one
    // whenever a demand competes in the same cycle.
    dmd_ready  = room_one;
    pf_ready   = dmd_valid ? room_two : room_one;
    take_dmd   = dmd_valid && dmd_ready;
    take_pf    = pf_valid && pf_ready;
  end

  AST_FULL_BLOCKS_ACCEPT: assert property (@(posedge clk) disable iff (!rst_n)
    full |-> (!dmd_ready && !pf_ready)); // R7

  AST_LAST_SLOT_TO_DEMAND: assert property (@(posedge clk) disable iff (!rst_n)
    (dmd_valid && pf_valid && free_slots == CNT_W'(1)) |-> (take_dmd && !take_pf)); // R8

endmodule

// File: rtl/mrq_store.sv
module mrq_store #(
  parameter int unsigned ADDR_W = 40,
  parameter int unsigned DEPTH  = 16,
  parameter int unsigned PTR_W  = $clog2(DEPTH),
  parameter int unsigned CNT_W  = $clog2(DEPTH + 1)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr0_en,
  input  logic [ADDR_W-1:0] wr0_addr,
  input  logic              wr0_pf,
  input  logic              wr1_en,
  input  logic [ADDR_W-1:0] wr1_addr,
  input  logic              wr1_pf,
  input  logic              rd_en,
  output logic [ADDR_W-1:0] head_addr,
  output logic              head_pf,
  output logic [CNT_W-1:0]  count
);

  logic [ADDR_W-1:0] slot_addr [DEPTH];
  logic              slot_pf   [DEPTH];

  logic [PTR_W-1:0] wr_ptr, wr_ptr_nxt, wr_ptr_p1;
  logic [PTR_W-1:0] rd_ptr, rd_ptr_nxt;
  logic [CNT_W-1:0] count_nxt;

  function automatic logic [PTR_W-1:0] bump(input logic [PTR_W-1:0] p);
    return (p == PTR_W'(DEPTH - 1)) ? '0 : p + PTR_W'(1);
  endfunction

  always_comb begin
    wr_ptr_p1  = bump(wr_ptr);
    wr_ptr_nxt = wr_ptr;
    if (wr1_en)      wr_ptr_nxt = bump(wr_ptr_p1);
    else if (wr0_en) wr_ptr_nxt = wr_ptr_p1;
    rd_ptr_nxt = rd_en ? bump(rd_ptr) : rd_ptr;
    count_nxt  = count + CNT_W'(wr0_en) + CNT_W'(wr1_en) - CNT_W'(rd_en);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      wr_ptr <= '0;
      rd_ptr <= '0;
      count  <= '0;
    end else begin
      wr_ptr <= wr_ptr_nxt;
      rd_ptr <= rd_ptr_nxt;
      count  <= count_nxt;
    end
  end

  // Payload storage carries no reset; only slots covered by count are read.
  always_ff @(posedge clk) begin
    if (wr0_en) begin
      slot_addr[wr_ptr] <= wr0_addr;
      slot_pf[wr_ptr]   <= wr0_pf;
    end
    if (wr1_en) begin
      slot_addr[wr_ptr_p1] <= wr1_addr;
      slot_pf[wr_ptr_p1]   <= wr1_pf;
    end
  end

  always_comb begin
    head_addr = slot_addr[rd_ptr];
    head_pf   = slot_pf[rd_ptr];
  end

  AST_NO_OVERFLOW: assert property (@(posedge clk) disable iff (!rst_n)
    count <= CNT_W'(DEPTH)); // R7

  AST_NO_UNDERFLOW: assert property (@(posedge clk) disable iff (!rst_n)
    rd_en |-> (count != '0)); // R1

  AST_SECOND_WRITE_FOLLOWS: assert property (@(posedge clk) disable iff (!rst_n)
    wr1_en |-> wr0_en); // R2

endmodule

// File: rtl/mrq_pacer.sv
module mrq_pacer #(
  parameter int unsigned GAP_W = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [GAP_W-1:0] gap_cfg,
  input  logic             fire,
  output logic             issue_ok
);

  logic [GAP_W-1:0] wait_cnt, wait_cnt_nxt;
  logic [GAP_W-1:0] reload_val;

  always_comb begin
    reload_val = (gap_cfg > GAP_W'(1)) ? gap_cfg - GAP_W'(1) : '0;
    issue_ok   = (wait_cnt == '0);
    if (fire)                 wait_cnt_nxt = reload_val;
    else if (wait_cnt != '0)  wait_cnt_nxt = wait_cnt - GAP_W'(1);
    else                      wait_cnt_nxt = wait_cnt;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) wait_cnt <= '0;
    else        wait_cnt <= wait_cnt_nxt;
  end

  AST_FIRE_ONLY_WHEN_OPEN: assert property (@(posedge clk) disable iff (!rst_n)
    fire |-> issue_ok); // R5

  AST_GAP_CLOSES_AFTER_FIRE: assert property (@(posedge clk) disable iff (!rst_n)
    (fire && gap_cfg >= GAP_W'(2)) |=> !issue_ok); // R5

  AST_NO_GAP_STAYS_OPEN: assert property (@(posedge clk) disable iff (!rst_n)
    (fire && gap_cfg <= GAP_W'(1)) |=> issue_ok); // R6

endmodule

// File: rtl/miss_req_queue.sv
module miss_req_queue
  import mrq_pkg::*;
#(
  parameter int unsigned ADDR_W    = 40,
  parameter int unsigned BLK_OFF_W = 6,
  parameter int unsigned DEPTH     = 16,
  parameter int unsigned GAP_W     = 8,
  localparam int unsigned PTR_W    = $clog2(DEPTH),
  localparam int unsigned CNT_W    = $clog2(DEPTH + 1)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              dmd_valid,
  input  logic [ADDR_W-1:0] dmd_addr,
  output logic              dmd_ready,
  input  logic              pf_valid,
  input  logic [ADDR_W-1:0] pf_addr,
  output logic              pf_ready,
  input  logic [GAP_W-1:0]  gap_cfg,
  output logic              out_valid,
  input  logic              out_ready,
  output logic [ADDR_W-1:0] out_addr,
  output logic              out_is_pf,
  output logic [CNT_W-1:0]  occupancy,
  output logic              full
);

  logic [ADDR_W-1:0] dmd_blk, pf_blk;
  logic              take_dmd, take_pf;
  logic              wr0_en, wr1_en, wr0_pf;
  logic [ADDR_W-1:0] wr0_addr;
  logic [CNT_W-1:0]  count;
  logic              issue_ok, fire;
  logic [ADDR_W-1:0] head_addr;
  logic              head_pf;

  // Block alignment: the offset field is cleared before storage.
  generate
    if (BLK_OFF_W == 0) begin : g_no_offset
      assign dmd_blk = dmd_addr;
      assign pf_blk  = pf_addr;
    end else begin : g_clear_offset
      assign dmd_blk = {dmd_addr[ADDR_W-1:BLK_OFF_W], {BLK_OFF_W{1'b0}}};
      assign pf_blk  = {pf_addr[ADDR_W-1:BLK_OFF_W], {BLK_OFF_W{1'b0}}};
    end
  endgenerate

  mrq_admit #(
    .DEPTH (DEPTH),
    .CNT_W (CNT_W)
  ) u_admit (
    .clk       (clk),
    .rst_n     (rst_n),
    .dmd_valid (dmd_valid),
    .pf_valid  (pf_valid),
    .count     (count),
    .dmd_ready (dmd_ready),
    .pf_ready  (pf_ready),
    .take_dmd  (take_dmd),
    .take_pf   (take_pf),
    .full      (full)
  );

  // The first write slot goes to the demand when present; a same-cycle
  // prefetch lands in the slot behind it.
  always_comb begin
    wr0_en   = take_dmd || take_pf;
    wr1_en   = take_dmd && take_pf;
    wr0_addr = take_dmd ? dmd_blk : pf_blk;
    wr0_pf   = take_dmd ? logic'(REQ_DEMAND) : logic'(REQ_PREFETCH);
  end

  mrq_store #(
    .ADDR_W (ADDR_W),
    .DEPTH  (DEPTH),
    .PTR_W  (PTR_W),
    .CNT_W  (CNT_W)
  ) u_store (
    .clk       (clk),
    .rst_n     (rst_n),
    .wr0_en    (wr0_en),
    .wr0_addr  (wr0_addr),
    .wr0_pf    (wr0_pf),
    .wr1_en    (wr1_en),
    .wr1_addr  (pf_blk),
    .wr1_pf    (logic'(REQ_PREFETCH)),
    .rd_en     (fire),
    .head_addr (head_addr),
    .head_pf   (head_pf),
    .count     (count)
  );

  mrq_pacer #(
    .GAP_W (GAP_W)
  ) u_pacer (
    .clk      (clk),
    .rst_n    (rst_n),
    .gap_cfg  (gap_cfg),
    .fire     (fire),
    .issue_ok (issue_ok)
  );

  always_comb begin
    out_valid = (count != '0) && issue_ok;
    fire      = out_valid && out_ready;
    out_addr  = head_addr;
    out_is_pf = head_pf;
    occupancy = count;
  end

  AST_HOLD_WHILE_STALLED: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && !out_ready) |=> (out_valid && $stable(out_addr) && $stable(out_is_pf))); // R10

  AST_FULL_MATCHES_COUNT: assert property (@(posedge clk) disable iff (!rst_n)
    full == (occupancy == CNT_W'(DEPTH))); // R7

  AST_ALIGNED_OUT: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid |-> (mrq_pkg::block_align(64'(out_addr), BLK_OFF_W) == 64'(out_addr))); // R3

endmodule

// File: tb/sim_miss_req_queue.sv
module sim_miss_req_queue;

  localparam int unsigned ADDR_W    = 40;
  localparam int unsigned BLK_OFF_W = 6;
  localparam int unsigned DEPTH     = 16;
  localparam int unsigned GAP_W     = 8;
  localparam int unsigned CNT_W     = $clog2(DEPTH + 1);

  logic              clk;
  logic              rst_n;
  logic              dmd_valid, pf_valid;
  logic [ADDR_W-1:0] dmd_addr, pf_addr;
  logic              dmd_ready, pf_ready;
  logic [GAP_W-1:0]  gap_cfg;
  logic              out_valid, out_ready, out_is_pf, full;
  logic [ADDR_W-1:0] out_addr;
  logic [CNT_W-1:0]  occupancy;

  miss_req_queue #(
    .ADDR_W(ADDR_W), .BLK_OFF_W(BLK_OFF_W), .DEPTH(DEPTH), .GAP_W(GAP_W)
  ) u0 (
    .clk(clk), .rst_n(rst_n),
    .dmd_valid(dmd_valid), .dmd_addr(dmd_addr), .dmd_ready(dmd_ready),
    .pf_valid(pf_valid), .pf_addr(pf_addr), .pf_ready(pf_ready),
    .gap_cfg(gap_cfg),
    .out_valid(out_valid), .out_ready(out_ready), .out_addr(out_addr),
    .out_is_pf(out_is_pf), .occupancy(occupancy), .full(full)
  );

  initial clk = 1'b0;
  always #2.5 clk = ~clk;  // 200 MHz

  int checks = 0;
  int fails  = 0;
  int cyc    = 0;
  int last_deq = 0;
  bit have_last = 0;
  int spacing = 0;
  string spacing_tag = "R5";
  logic [ADDR_W:0] exp_q[$];
  bit done = 0;

  function automatic logic [ADDR_W-1:0] blk(input logic [ADDR_W-1:0] a);
    return a & ~((ADDR_W'(1) << BLK_OFF_W) - ADDR_W'(1));
  endfunction

  function automatic logic [ADDR_W-1:0] pat(input int i);
    return ADDR_W'(40'h12_3456_0000) + ADDR_W'(i) * ADDR_W'(40'h1_0421) + ADDR_W'(7 + i);
  endfunction

  task automatic check(input string req, input logic [63:0] act, input logic [63:0] expv);
    checks++;
    if (act !== expv) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, expv);
    end
  endtask

  // Monitor / scoreboard: pops on departures, pushes on acceptances.
  always @(negedge clk) begin
    if (rst_n) begin
      cyc++;
      if (out_valid && out_ready) begin
        checks++;
        if (exp_q.size() == 0) begin
          fails++;
          $display("FAIL R1 actual=%0h expected=<nothing>", {out_is_pf, out_addr});
        end else begin
          logic [ADDR_W:0] e;
          e = exp_q.pop_front();
          if ({out_is_pf, out_addr} !== e) begin
            fails++;
            $display("FAIL R1/R2/R3/R4 actual=%0h expected=%0h", {out_is_pf, out_addr}, e);
          end
        end
        if (have_last && spacing != 0) begin
          checks++;
          if (cyc - last_deq != spacing) begin
            fails++;
            $display("FAIL %s spacing actual=%0d expected=%0d", spacing_tag, cyc - last_deq, spacing);
          end
        end
        have_last = 1;
        last_deq  = cyc;
      end
      if (dmd_valid && dmd_ready) exp_q.push_back({1'b0, blk(dmd_addr)});
      if (pf_valid && pf_ready)   exp_q.push_back({1'b1, blk(pf_addr)});
    end
  end

  // Bench sits at posedge+1 between tasks.
  task automatic drive(input bit dv, input logic [ADDR_W-1:0] da,
                       input bit pv, input logic [ADDR_W-1:0] pa);
    dmd_valid = dv; dmd_addr = da; pf_valid = pv; pf_addr = pa;
    @(posedge clk); #1;
    dmd_valid = 0; pf_valid = 0;
  endtask

  task automatic drain(input int sp, input string tag);
    spacing = sp; spacing_tag = tag; have_last = 0;
    out_ready = 1;
    while (exp_q.size() != 0 || occupancy != '0) begin
      @(posedge clk); #1;
    end
    out_ready = 0; spacing = 0; have_last = 0;
    check("R11 drained occupancy", 64'(occupancy), 64'd0);
  endtask

  task automatic do_reset();
    rst_n = 0;
    repeat (2) @(posedge clk);
    exp_q.delete();
    #1 rst_n = 1;
    @(posedge clk); #1;
  endtask

  initial begin : watchdog
    repeat (100000) @(posedge clk);
    if (!done) begin
      fails++;
      $display("FAIL watchdog actual=timeout expected=finish");
      $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
      $finish;
    end
  end

  initial begin
    logic [ADDR_W-1:0] held;
    dmd_valid = 0; pf_valid = 0; dmd_addr = '0; pf_addr = '0;
    out_ready = 0; gap_cfg = 8'd1;
    rst_n = 0;
    repeat (3) @(posedge clk);
    #1 rst_n = 1;
    @(posedge clk); #1;

    // R9: reset state
    check("R9 occupancy", 64'(occupancy), 64'd0);
    check("R9 full", 64'(full), 64'd0);
    check("R9 out_valid", 64'(out_valid), 64'd0);
    check("R7 dmd_ready when empty", 64'(dmd_ready), 64'd1);

    // R1/R3/R4: mixed single requests, output open
    out_ready = 1;
    for (int i = 0; i < 8; i++) begin
      if (i % 3 == 1) drive(0, '0, 1, pat(i));
      else            drive(1, pat(i), 0, '0);
    end
    drain(0, "R1");

    // R2/R6: paired arrivals stored while stalled, then drained every cycle
    for (int i = 0; i < 5; i++) drive(1, pat(20 + i), 1, pat(40 + i));
    check("R11 occupancy after pairs", 64'(occupancy), 64'd10);
    drain(1, "R6");

    // R7/R10/R11: fill completely
    for (int i = 0; i < DEPTH; i++) drive(1, pat(60 + i), 0, '0);
    check("R11 occupancy full", 64'(occupancy), 64'(DEPTH));
    check("R7 full flag", 64'(full), 64'd1);
    dmd_valid = 1; pf_valid = 1; dmd_addr = pat(99); pf_addr = pat(98);
    @(negedge clk);
    check("R7 dmd_ready when full", 64'(dmd_ready), 64'd0);
    check("R7 pf_ready when full", 64'(pf_ready), 64'd0);
    held = out_addr;
    @(posedge clk); #1;
    dmd_valid = 0; pf_valid = 0;
    repeat (3) @(posedge clk);
    @(negedge clk);
    check("R10 out_valid held", 64'(out_valid), 64'd1);
    check("R10 out_addr stable", 64'(out_addr), 64'(held));
    check("R7 occupancy unchanged when refused", 64'(occupancy), 64'(DEPTH));
    @(posedge clk); #1;
    drain(1, "R6");

    // R8: one slot left, both arrive
    for (int i = 0; i < DEPTH - 1; i++) drive(0, '0, 1, pat(80 + i));
    dmd_valid = 1; pf_valid = 1; dmd_addr = pat(120); pf_addr = pat(121);
    @(negedge clk);
    check("R8 dmd_ready last slot", 64'(dmd_ready), 64'd1);
    check("R8 pf_ready last slot", 64'(pf_ready), 64'd0);
    @(posedge clk); #1;
    dmd_valid = 0; pf_valid = 0;
    check("R8 occupancy", 64'(occupancy), 64'(DEPTH));

    // R5: spacing of 10 from a full queue
    gap_cfg = 8'd10;
    drain(10, "R5");

    // R5: spacing of 3 with paired arrivals
    gap_cfg = 8'd3;
    repeat (12) @(posedge clk); #1;
    for (int i = 0; i < 4; i++) drive(1, pat(130 + i), 1, pat(140 + i));
    drain(3, "R5");

    // R6: setting 0 behaves as every cycle
    gap_cfg = 8'd0;
    repeat (4) @(posedge clk); #1;
    for (int i = 0; i < 6; i++) drive(i % 2 == 0, pat(150 + i), 1, pat(160 + i));
    drain(1, "R6");

    // R9: reset during a countdown clears it; first request issues at once
    gap_cfg = 8'd10;
    for (int i = 0; i < 3; i++) drive(1, pat(170 + i), 0, '0);
    out_ready = 1;
    @(posedge clk); #1;
    out_ready = 0;
    do_reset();
    check("R9 occupancy after reset", 64'(occupancy), 64'd0);
    drive(1, pat(180), 0, '0);
    @(negedge clk);
    check("R9 first offer after reset", 64'(out_valid), 64'd1);
    @(posedge clk); #1;
    drain(0, "R5");

    done = 1;
    $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
    $finish;
  end

endmodule